// File: doc/BRIEF.md
# Dual-Prescaler Capture/Compare Timer

A single 16-bit timer channel. The clock is divided by a primary 8-bit prescaler and then by a secondary 8-bit prescaler in series. The result is a count enable, or "tick", for a 16-bit up-counter. Each prescaler divides by its programmed value plus one. The combined ratio is therefore (primary + 1) × (secondary + 1), anywhere from 1 to 65,536.

Two events are kept as separate sticky flags, each with its own interrupt enable:
- **Reference event:** the counter reaches a programmable reference value.
- **Capture event:** a rising edge on an external strobe latches the running count.

Software reaches everything through a synchronous word-addressed read/write port with one cycle of read latency. Register map (word address: contents):
- **0, control:** bit 0 run, bit 1 restart mode, bit 2 reference interrupt enable, bit 3 capture interrupt enable, bits 15:8 secondary divider.
- **1, primary divider:** bits 7:0.
- **2, reference value.**
- **3, capture value:** read-only.
- **4, counter:** read/write.
- **5, event flags:** bit 15 capture, bit 14 reference, write-1-to-clear.

The prescale values are sampled when the run bit goes from 0 to 1. Program the divider before starting the timer.

Top module: `dd_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: With secondary divider 0 and primary divider P, the counter advances once every P+1 clock cycles while running. The first advance comes P+1 cycles after the enabling write.
- R3: With primary P and secondary S, the counter advances once every (P+1)·(S+1) cycles. This includes the maximum of 65,536 when both are 0xFF.
- R4: Both divider values are captured on the write that sets run from 0 to 1. A later write to the primary divider (address 1) while running has no effect until the next 0-to-1 start.
- R5: The counter can be written and read at address 4. A write takes priority over a tick. In free-run mode (control bit 1 = 0) the count wraps from 0xFFFF to 0.
- R6: In restart mode (control bit 1 = 1), the first tick after the counter holds the reference value loads 0.
- R7: The reference flag (event bit 14) is set on the tick that loads the counter with the reference value.
- R8: `cap_in` passes through two synchronising flops. Its rising edge copies the counter into the capture register (address 3) and sets the capture flag (event bit 15), whether or not the timer is running. The copy is taken two clock edges after the first edge that samples `cap_in` high.
- R9: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. If an event and a clear land on the same edge, the flag stays set.
- R10: `irq` is registered. It equals (reference flag AND control bit 2) OR (capture flag AND control bit 3), one cycle after the flags and enables. It stays high until the flag is cleared.
- R11: Event bits 13:0 read 0. While run is 0 the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid one cycle after `rd_en` |
| cap_in | input | 1 | Asynchronous capture strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume the following about the inputs:
- Each write to the counter is an isolated software action, so a tick that coincides with it is simply dropped.
- `cap_in` holds each level for at least one full clock cycle, so the synchroniser reports one clean edge per pulse.
- The reserved address codes 6 and 7 are never written.

The stimulus keeps within these limits:
- All inputs change on the falling edge.
- The capture strobe is held for several cycles.
- Divider values are changed only while the timer is stopped, except in the one case that checks a running write is ignored.

// File: rtl/dd_timer_pkg.sv
package dd_timer_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRI  = 3'd1;
  localparam logic [ADDR_W-1:0] A_REF  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_EVT  = 3'd5;

  localparam int unsigned B_RUN     = 0;
  localparam int unsigned B_RESTART = 1;
  localparam int unsigned B_REF_IE  = 2;
  localparam int unsigned B_CAP_IE  = 3;
  localparam int unsigned B_SEC_LSB = 8;

  typedef struct packed {
    logic run;
    logic restart;
    logic ref_ie;
    logic cap_ie;
  } ctrl_t;
endpackage

// File: rtl/dd_prescale.sv
module dd_prescale #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] pri_div,
  input  logic [DIV_W-1:0] sec_div,
  output logic             tick
);
  logic [DIV_W-1:0] p_act, s_act, p_cnt, s_cnt;
  logic             p_wrap, s_wrap;

  assign p_wrap = (p_cnt == p_act);
  assign s_wrap = (s_cnt == s_act);
  assign tick   = run && p_wrap && s_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_act <= '0;
      s_act <= '0;
      p_cnt <= '0;
      s_cnt <= '0;
    end else if (start) begin
      p_act <= pri_div;
      s_act <= sec_div;
      p_cnt <= '0;
      s_cnt <= '0;
    end else if (run) begin
      if (p_wrap) begin
        p_cnt <= '0;
        s_cnt <= s_wrap ? '0 : s_cnt + 1'b1;
      end else begin
        p_cnt <= p_cnt + 1'b1;
      end
    end
  end

  // R2: a primary divide above one leaves a gap after every tick
  a_r2_primary_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && p_act != '0 && !start) |=> !tick);
  // R3: a secondary divide above one also leaves a gap after every tick
  a_r3_secondary_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && s_act != '0 && !start) |=> !tick);
endmodule

// File: rtl/dd_counter.sv
module dd_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cap_pulse,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_val,
  output logic             ref_hit
);
  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    if (restart && cnt == ref_val) cnt_next = '0;
    else                           cnt_next = cnt + 1'b1;
  end

  assign ref_hit = tick && !cnt_we && (cnt_next == ref_val);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (cnt_we)  cnt <= cnt_wdata;
    else if (tick)    cnt <= cnt_next;
  end

  always_ff @(posedge clk) begin
    if (rst)            cap_val <= '0;
    else if (cap_pulse) cap_val <= cnt;
  end

  // R6: restart mode returns to zero after the reference value
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_we && restart && cnt == ref_val) |=> cnt == '0);
  // R5: free-run wraps at the top
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_we && !restart && cnt == '1) |=> cnt == '0);
  // R8: capture latches the count present at the strobe
  a_r8_latch: assert property (@(posedge clk) disable iff (rst)
    cap_pulse |=> cap_val == $past(cnt));
  // R11: no tick and no write keep the count still
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_we) |=> $stable(cnt));
endmodule

// File: rtl/dd_events.sv
module dd_events #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cap_in,
  input  logic ref_hit,
  input  logic clr_ref,
  input  logic clr_cap,
  input  logic ref_ie,
  input  logic cap_ie,
  output logic cap_pulse,
  output logic ref_flag,
  output logic cap_flag,
  output logic irq
);
  logic [SYNC_N:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_N-1:0], cap_in};
  end

  assign cap_pulse = sh[SYNC_N-1] && !sh[SYNC_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_flag <= 1'b0;
      cap_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      ref_flag <= ref_hit   || (ref_flag && !clr_ref);
      cap_flag <= cap_pulse || (cap_flag && !clr_cap);
      irq      <= (ref_flag && ref_ie) || (cap_flag && cap_ie);
    end
  end

  // R9: a set on the same edge as a clear wins
  a_r9_ref_set_wins: assert property (@(posedge clk) disable iff (rst)
    ref_hit |=> ref_flag);
  a_r9_cap_set_wins: assert property (@(posedge clk) disable iff (rst)
    cap_pulse |=> cap_flag);
  // R9: a clear with no event drops the flag
  a_r9_ref_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_ref && !ref_hit) |=> !ref_flag);
  // R8: one edge yields a single capture pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cap_pulse |=> !cap_pulse);
  // R10: no flags, no request on the following cycle
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    (!ref_flag && !cap_flag) |=> !irq);
endmodule

// File: rtl/dd_timer.sv
module dd_timer
  import dd_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              cap_in,
  output logic              irq
);
  localparam int unsigned EV_CAP = CNT_W - 1;
  localparam int unsigned EV_REF = CNT_W - 2;
  localparam int unsigned SEC_HI = B_SEC_LSB + DIV_W - 1;

  ctrl_t            ctl_q;
  logic [DIV_W-1:0] sec_q, pri_q;
  logic [CNT_W-1:0] ref_q, cnt, cap_val;
  logic             start, tick, cap_pulse, ref_hit, ref_flag, cap_flag;
  logic             wr_ctrl, wr_cnt, wr_evt;

  assign wr_ctrl = wr_en && addr == A_CTRL;
  assign wr_cnt  = wr_en && addr == A_CNT;
  assign wr_evt  = wr_en && addr == A_EVT;
  assign start   = wr_ctrl && wr_data[B_RUN] && !ctl_q.run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      sec_q <= '0;
      pri_q <= '0;
      ref_q <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) begin
        ctl_q.run     <= wr_data[B_RUN];
        ctl_q.restart <= wr_data[B_RESTART];
        ctl_q.ref_ie  <= wr_data[B_REF_IE];
        ctl_q.cap_ie  <= wr_data[B_CAP_IE];
        sec_q         <= wr_data[SEC_HI:B_SEC_LSB];
      end
      if (addr == A_PRI) pri_q <= wr_data[DIV_W-1:0];
      if (addr == A_REF) ref_q <= wr_data;
    end
  end

  dd_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .start(start), .run(ctl_q.run),
    .pri_div(pri_q), .sec_div(wr_data[SEC_HI:B_SEC_LSB]), .tick(tick)
  );

  dd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .restart(ctl_q.restart),
    .ref_val(ref_q), .cnt_we(wr_cnt), .cnt_wdata(wr_data),
    .cap_pulse(cap_pulse), .cnt(cnt), .cap_val(cap_val), .ref_hit(ref_hit)
  );

  dd_events #(.SYNC_N(SYNC_N)) u_evt (
    .clk(clk), .rst(rst), .cap_in(cap_in), .ref_hit(ref_hit),
    .clr_ref(wr_evt && wr_data[EV_REF]), .clr_cap(wr_evt && wr_data[EV_CAP]),
    .ref_ie(ctl_q.ref_ie), .cap_ie(ctl_q.cap_ie), .cap_pulse(cap_pulse),
    .ref_flag(ref_flag), .cap_flag(cap_flag), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= '0;
      case (addr)
        A_CTRL: begin
          rd_data[B_RUN]             <= ctl_q.run;
          rd_data[B_RESTART]         <= ctl_q.restart;
          rd_data[B_REF_IE]          <= ctl_q.ref_ie;
          rd_data[B_CAP_IE]          <= ctl_q.cap_ie;
          rd_data[SEC_HI:B_SEC_LSB]  <= sec_q;
        end
        A_PRI:   rd_data[DIV_W-1:0] <= pri_q;
        A_REF:   rd_data <= ref_q;
        A_CAP:   rd_data <= cap_val;
        A_CNT:   rd_data <= cnt;
        A_EVT: begin
          rd_data[EV_CAP] <= cap_flag;
          rd_data[EV_REF] <= ref_flag;
        end
        default: rd_data <= '0;
      endcase
    end
  end

  // R11: reserved event bits read back as zero
  a_r11_evt_reserved: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_EVT) |=> rd_data[EV_REF-1:0] == '0);
  // R4: a start leaves the timer running
  a_r4_start_runs: assert property (@(posedge clk) disable iff (rst)
    start |=> ctl_q.run);
endmodule

// File: tb/sim_dd_timer.sv
module sim_dd_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, cap_in = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dd_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cap_in(cap_in), .irq(irq)
  );

  typedef struct packed {
    logic [7:0]  pri;
    logic [7:0]  sec;
    logic [31:0] cycles;
    logic [15:0] expect_cnt;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'd0, 8'd0, 32'd10, 16'd10},
    '{8'd1, 8'd0, 32'd10, 16'd5},
    '{8'd4, 8'd0, 32'd23, 16'd4},
    '{8'd0, 8'd2, 32'd9,  16'd3},
    '{8'd1, 8'd1, 32'd17, 16'd4},
    '{8'd2, 8'd3, 32'd24, 16'd2},
    '{8'd7, 8'd0, 32'd16, 16'd2},
    '{8'd0, 8'd0, 32'd1,  16'd1}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic run_div(input logic [7:0] p, input logic [7:0] s, input int t);
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'h0000);
    wr(3'd1, {8'h00, p});
    wr(3'd0, {s, 8'h01});
    repeat (t - 1) @(negedge clk);
    wr(3'd0, {s, 8'h00});
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v, v2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, 16'h0);
    rd(3'd4, v); check("R1 count", v, 16'h0);
    rd(3'd5, v); check("R1 events", v, 16'h0);
    rd(3'd3, v); check("R1 capture", v, 16'h0);
    check("R1 irq", {15'd0, irq}, 16'h0);

    // R2 R3 divide ratios from the vector table
    foreach (VECS[i]) begin
      run_div(VECS[i].pri, VECS[i].sec, int'(VECS[i].cycles));
      rd(3'd4, v);
      check(VECS[i].sec == 0 ? "R2 primary divide" : "R3 combined divide", v, VECS[i].expect_cnt);
    end

    // R3 maximum ratio 65536
    run_div(8'hFF, 8'hFF, 65535);
    rd(3'd4, v); check("R3 max ratio one short", v, 16'd0);
    run_div(8'hFF, 8'hFF, 65536);
    rd(3'd4, v); check("R3 max ratio", v, 16'd1);

    // R4 divider snapshot at start
    wr(3'd0, 16'h0000); wr(3'd4, 16'h0000); wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'h0003);
    repeat (6) @(negedge clk);
    wr(3'd0, 16'h0000);
    rd(3'd4, v); check("R4 running write ignored", v, 16'd8);
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h0001);
    repeat (7) @(negedge clk);
    wr(3'd0, 16'h0000);
    rd(3'd4, v); check("R4 new divider after restart", v, 16'd2);

    // R5 write and wrap
    wr(3'd1, 16'h0000);
    wr(3'd4, 16'hFFFE);
    rd(3'd4, v); check("R5 count write", v, 16'hFFFE);
    wr(3'd0, 16'h0001);
    repeat (2) @(negedge clk);
    wr(3'd0, 16'h0000);
    rd(3'd4, v); check("R5 wrap", v, 16'd1);

    // R6 R7 R10 restart mode with reference interrupt
    wr(3'd5, 16'hC000);
    wr(3'd4, 16'h0000);
    wr(3'd2, 16'd3);
    wr(3'd0, 16'h0007);
    repeat (5) @(negedge clk);
    wr(3'd0, 16'h0006);
    rd(3'd4, v); check("R6 restart", v, 16'd2);
    rd(3'd5, v); check("R7 reference flag", v, 16'h4000);
    check("R10 irq on reference", {15'd0, irq}, 16'h1);
    // R9 write of zero leaves the flag
    wr(3'd5, 16'h0000);
    rd(3'd5, v); check("R9 write zero", v, 16'h4000);
    wr(3'd5, 16'h4000);
    rd(3'd5, v); check("R9 clear", v, 16'h0000);
    check("R10 irq released", {15'd0, irq}, 16'h0);

    // R8 capture while stopped
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'h1234);
    cap_in = 1'b1;
    repeat (4) @(negedge clk);
    cap_in = 1'b0;
    repeat (2) @(negedge clk);
    rd(3'd3, v); check("R8 captured value", v, 16'h1234);
    rd(3'd5, v); check("R8 capture flag", v, 16'h8000);
    check("R10 irq masked", {15'd0, irq}, 16'h0);
    wr(3'd0, 16'h0008);
    @(negedge clk);
    check("R10 irq on capture", {15'd0, irq}, 16'h1);

    // R9 set wins over a clear on the same edge
    cap_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(3'd5, 16'h8000);
    rd(3'd5, v); check("R9 set wins", v, 16'h8000);
    wr(3'd5, 16'h8000);
    rd(3'd5, v); check("R9 clear after", v, 16'h0000);
    cap_in = 1'b0;
    repeat (3) @(negedge clk);

    // R7 R11 reference in free run, reserved bits, hold when stopped
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd5);
    wr(3'd4, 16'd4);
    wr(3'd0, 16'h0001);
    wr(3'd0, 16'h0000);
    cap_in = 1'b1;
    repeat (4) @(negedge clk);
    cap_in = 1'b0;
    rd(3'd5, v); check("R11 reserved bits", v, 16'hC000);
    rd(3'd4, v);
    repeat (10) @(negedge clk);
    rd(3'd4, v2);
    check("R11 hold when stopped", v2, v);
    check("R7 free-run reference count", v, 16'd5);

    finish_run();
  end
endmodule